// File: doc/BRIEF.md
# No-Turnaround Pipelined Burst SRAM

This block is a synchronous single-port memory of 256 words by 36 bits. Each word is split into four 9-bit byte lanes. A read or a write can be issued on every clock, and reads and writes can alternate freely. No idle cycle is needed when the traffic switches direction. Read data returns two rising edges after the command. Write data is taken at the second rising edge after its command, so the data slot of a write lines up with the data slot of a read. The data bus therefore stays busy on every cycle.

The write address and lane selects wait in a short registry until the data arrives. A read that follows a write to the same word still returns that write's lanes, merged over the stored word.

A command is either a load, which gives a fresh address, or an advance, which steps a 4-beat burst through the two low address bits. The burst order is linear or XOR-interleaved. Three other inputs gate the block:
- An active-low clock enable freezes every register.
- Three chip enables select the device.
- An asynchronous sleep input parks the block in a quiet state.

The data pins are modelled as separate `din` and `dq_out` ports, plus a drive-enable output `dq_en`. When `dq_en` is low, the pins are read as high impedance.

Top module: `nbl_sram`

## Requirements
- R1: Read data for a command captured at rising edge k is on `dq_out` with `dq_en` high from edge k+1 until the next update, counting only enabled edges.
- R2: Reads and writes may be issued on consecutive cycles in any order, and every one of them takes effect with no idle cycle in between.
- R3: While `cke_n` is high, every register holds its value, and `dq_out` and `dq_en` do not change.
- R4: Lane i is `din[9i+8:9i]`. A low `wr_lane_n[i]` writes lane i. A write with all four selects high leaves the word unchanged.
- R5: The lane selects are sampled on every beat of a burst write, so each beat writes only the lanes selected on that beat.
- R6: With `ld_n` low, the block takes a new address, command and chip-enable state. With `ld_n` high, it advances the current burst: the upper address bits stay fixed, and `wr_n` and the chip enables are ignored.
- R7: `burst_ord` is sampled at a load. Value 0 gives beat n the low bits (base+n) mod 4. Value 1 gives it base XOR n.
- R8: Write data is captured at the second enabled edge after the write command, and `dq_en` is low during that data slot. `oe_n` high forces `dq_en` low at once.
- R9: A load selects the device only when `ce_a_n`=0, `ce_b_n`=0 and `ce_c`=1. Any other combination is a deselect, and `dq_en` is low in that command's data slot.
- R10: Two edges after `sleep` rises, commands are ignored and `dq_en` is low. Two edges after `sleep` falls, the block accepts commands again. The array contents are kept, and `dq_en` stays low on exit.
- R11: A read issued right after a write to the same address returns that write's selected lanes, merged over the stored word.
- R12: After reset, `dq_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b_n | input | 1 | Chip enable, active low |
| ce_c | input | 1 | Chip enable, active high |
| wr_n | input | 1 | Low = write, high = read (sampled at load) |
| ld_n | input | 1 | Low = load new command, high = advance burst |
| burst_ord | input | 1 | 0 linear, 1 interleaved (sampled at load) |
| wr_lane_n | input | 4 | Active-low byte-lane write selects |
| addr | input | 8 | Word address |
| din | input | 36 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request |
| dq_out | output | 36 | Registered read data |
| dq_en | output | 1 | Data pin drive enable |

## Verification
A read of a word can be in its address phase on the same edge where the data of an earlier write to that word is being captured. This is the clash between the write registry and the read path. The bench provokes it by issuing a partial-lane write, then in the next cycle a read of the same address. That read meets the write data on the same edge.

The expected word is built in the bench from the lane rule: the selected lanes come from the new data and the other lanes from the older word. A second case writes with no lanes selected right before a read, to show that a pending empty write forwards nothing.

// File: rtl/nbl_pkg.sv
package nbl_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_ord_e;

  // Low address bits of a burst beat
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] beat,
                                          input burst_ord_e ord);
    return (ord == ORD_XOR) ? (base ^ beat) : (base + beat);
  endfunction
endpackage

// File: rtl/nbl_burst_addr.sv
module nbl_burst_addr
  import nbl_pkg::*;
#(
  parameter int AW = 8,
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          flush,
  input  logic          ld_n,
  input  logic          sel,
  input  logic          wr_n,
  input  burst_ord_e    ord,
  input  logic [AW-1:0] addr_in,
  input  logic [NL-1:0] lane_n_in,
  output logic          s1_valid,
  output logic          s1_wr,
  output logic [AW-1:0] s1_addr,
  output logic [NL-1:0] s1_lanes
);
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  burst_ord_e    ord_q, ord_d;
  logic          act_q, act_d, wr_q, wr_d;
  logic          v_d;
  logic [AW-1:0] a_d;
  logic [NL-1:0] lanes_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    ord_d  = ord_q;
    act_d  = act_q;
    wr_d   = wr_q;
    if (!ld_n) begin
      base_d = addr_in;
      cnt_d  = 2'd0;
      ord_d  = ord;
      act_d  = sel;
      wr_d   = sel & ~wr_n;
    end else begin
      cnt_d = cnt_q + 2'd1;
    end
    v_d     = act_d;
    a_d     = {base_d[AW-1:2], beat_low(base_d[1:0], cnt_d, ord_d)};
    lanes_d = (act_d && wr_d) ? ~lane_n_in : '0;
    if (flush) begin
      act_d   = 1'b0;
      v_d     = 1'b0;
      lanes_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      ord_q    <= ORD_LINEAR;
      act_q    <= 1'b0;
      wr_q     <= 1'b0;
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
      s1_lanes <= '0;
    end else if (run || flush) begin
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      ord_q    <= ord_d;
      act_q    <= act_d;
      wr_q     <= wr_d;
      s1_valid <= v_d;
      s1_wr    <= wr_d;
      s1_addr  <= a_d;
      s1_lanes <= lanes_d;
    end
  end

  // R6
  burst_upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !flush && ld_n && act_q) |=> $stable(s1_addr[AW-1:2]));
endmodule

// File: rtl/nbl_wr_registry.sv
module nbl_wr_registry #(
  parameter int AW = 8,
  parameter int NL = 4,
  parameter int LW = 9,
  localparam int DW = NL * LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          flush,
  input  logic [AW-1:0] s1_addr,
  input  logic [NL-1:0] s1_lanes,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] arr_rdata,
  output logic [NL-1:0] we_lanes,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] rd_merged
);
  logic [AW-1:0] s2_addr;
  logic [NL-1:0] s2_lanes;
  logic          hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_addr  <= '0;
      s2_lanes <= '0;
    end else if (run || flush) begin
      s2_addr  <= s1_addr;
      s2_lanes <= flush ? '0 : s1_lanes;
    end
  end

  assign we_lanes = run ? s2_lanes : '0;
  assign waddr    = s2_addr;
  assign hit      = (s2_addr == s1_addr);

  for (genvar g = 0; g < NL; g++) begin : g_fwd
    assign rd_merged[g*LW +: LW] = (hit && s2_lanes[g]) ? din[g*LW +: LW]
                                                        : arr_rdata[g*LW +: LW];
  end

  // R10
  sleep_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (s2_lanes == '0));
endmodule

// File: rtl/nbl_lane_mem.sv
module nbl_lane_mem #(
  parameter int AW = 8,
  parameter int NL = 4,
  parameter int LW = 9,
  localparam int DW = NL * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [NL-1:0] we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LW +: LW];
    end
    assign rdata[g*LW +: LW] = mem[raddr];
  end
endmodule

// File: rtl/nbl_sram.sv
module nbl_sram
  import nbl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              ce_a_n,
  input  logic              ce_b_n,
  input  logic              ce_c,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic              burst_ord,
  input  logic [LANES-1:0]  wr_lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_en
);
  logic rst_meta, rst_i;
  logic slp_q1, asleep;
  logic run, flush;

  logic              s1_valid, s1_wr;
  logic [ADDR_W-1:0] s1_addr, waddr;
  logic [LANES-1:0]  s1_lanes, we_lanes;
  logic [DATA_W-1:0] arr_rdata, rd_merged;

  logic              out_en_q, out_en_d;
  logic [DATA_W-1:0] dq_q, dq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      slp_q1 <= 1'b0;
      asleep <= 1'b0;
    end else begin
      slp_q1 <= sleep;
      asleep <= slp_q1;
    end
  end

  assign run   = ~cke_n & ~asleep;
  assign flush = asleep;

  nbl_burst_addr #(.AW(ADDR_W), .NL(LANES)) u_burst (
    .clk      (clk),
    .rst_n    (rst_i),
    .run      (run),
    .flush    (flush),
    .ld_n     (ld_n),
    .sel      (~ce_a_n & ~ce_b_n & ce_c),
    .wr_n     (wr_n),
    .ord      (burst_ord_e'(burst_ord)),
    .addr_in  (addr),
    .lane_n_in(wr_lane_n),
    .s1_valid (s1_valid),
    .s1_wr    (s1_wr),
    .s1_addr  (s1_addr),
    .s1_lanes (s1_lanes)
  );

  nbl_wr_registry #(.AW(ADDR_W), .NL(LANES), .LW(LANE_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_i),
    .run      (run),
    .flush    (flush),
    .s1_addr  (s1_addr),
    .s1_lanes (s1_lanes),
    .din      (din),
    .arr_rdata(arr_rdata),
    .we_lanes (we_lanes),
    .waddr    (waddr),
    .rd_merged(rd_merged)
  );

  nbl_lane_mem #(.AW(ADDR_W), .NL(LANES), .LW(LANE_W)) u_mem (
    .clk  (clk),
    .we   (we_lanes),
    .waddr(waddr),
    .wdata(din),
    .raddr(s1_addr),
    .rdata(arr_rdata)
  );

  always_comb begin
    out_en_d = out_en_q;
    dq_d     = dq_q;
    if (flush) begin
      out_en_d = 1'b0;
    end else if (run) begin
      out_en_d = s1_valid & ~s1_wr;
      if (s1_valid && !s1_wr) dq_d = rd_merged;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      out_en_q <= 1'b0;
      dq_q     <= '0;
    end else begin
      out_en_q <= out_en_d;
      dq_q     <= dq_d;
    end
  end

  assign dq_out = dq_q;
  assign dq_en  = out_en_q & ~oe_n & ~asleep;

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (cke_n && !slp_q1 && !asleep) |=> ($stable(dq_q) && $stable(out_en_q)));

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i)
    asleep |=> !out_en_q);

  // R9
  drive_from_read_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(out_en_q) |-> $past(s1_valid && !s1_wr && !cke_n));
endmodule

// File: tb/nbl_sram_tb.sv
module nbl_sram_tb;
  localparam logic [2:0] SEL = 3'b001;
  localparam logic [2:0] DES = 3'b110;
  localparam logic [35:0] ZW  = 36'h0;
  localparam logic [35:0] D0  = {9'h0A1, 9'h0B2, 9'h0C3, 9'h0D4};
  localparam logic [35:0] D1  = {9'h155, 9'h066, 9'h177, 9'h088};
  localparam logic [35:0] D2  = {9'h1E5, 9'h1F6, 9'h107, 9'h118};
  localparam logic [35:0] D3  = {9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF};
  localparam logic [35:0] M02 = {9'h0A1, 9'h1F6, 9'h0C3, 9'h118};
  localparam logic [35:0] P   = {9'h011, 9'h022, 9'h033, 9'h044};
  localparam logic [35:0] B0  = {9'h101, 9'h102, 9'h103, 9'h104};
  localparam logic [35:0] B1  = {9'h111, 9'h112, 9'h113, 9'h114};
  localparam logic [35:0] B2  = {9'h121, 9'h122, 9'h123, 9'h124};
  localparam logic [35:0] B3  = {9'h131, 9'h132, 9'h133, 9'h134};
  localparam logic [35:0] W20 = {P[35:18], B3[17:0]};

  typedef struct packed {
    logic        cke_n;
    logic        sel;
    logic        wr;
    logic        ld_n;
    logic        ilv;
    logic [3:0]  bw_n;
    logic [7:0]  a;
    logic [35:0] d;
    logic [1:0]  chk;   // 0 none, 1 driven data, 2 high-Z
    logic [35:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    {1'b0,1'b1,1'b1,1'b0,1'b0,4'h0,8'h10,ZW,2'd0,ZW},
    {1'b0,1'b1,1'b1,1'b0,1'b0,4'h0,8'h11,ZW,2'd2,ZW},
    {1'b0,1'b1,1'b0,1'b0,1'b0,4'hF,8'h10,D0,2'd2,ZW},
    {1'b0,1'b1,1'b1,1'b0,1'b0,4'hA,8'h10,D1,2'd2,ZW},
    {1'b0,1'b1,1'b0,1'b0,1'b0,4'hF,8'h10,ZW,2'd1,D0},
    {1'b0,1'b1,1'b0,1'b0,1'b0,4'hF,8'h11,D2,2'd2,ZW},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,ZW,2'd1,M02},
    {1'b0,1'b1,1'b0,1'b0,1'b0,4'hF,8'h10,ZW,2'd1,D1},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,ZW,2'd2,ZW},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,ZW,2'd1,M02},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,ZW,2'd2,ZW},
    {1'b0,1'b1,1'b1,1'b0,1'b0,4'hF,8'h11,ZW,2'd2,ZW},
    {1'b0,1'b1,1'b0,1'b0,1'b0,4'hF,8'h11,ZW,2'd2,ZW},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,D3,2'd2,ZW},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,ZW,2'd1,D1},
    {1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,8'h00,ZW,2'd2,ZW}
  };

  logic clk = 1'b0;
  logic rst_n, cke_n, ce_a_n, ce_b_n, ce_c, wr_n, ld_n, burst_ord, oe_n, sleep;
  logic [3:0]  wr_lane_n;
  logic [7:0]  addr;
  logic [35:0] din, dq_out;
  logic        dq_en;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nbl_sram u_dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n),
    .ce_c(ce_c), .wr_n(wr_n), .ld_n(ld_n), .burst_ord(burst_ord),
    .wr_lane_n(wr_lane_n), .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep),
    .dq_out(dq_out), .dq_en(dq_en)
  );

  task automatic step(input logic ck, input logic [2:0] ce, input logic w,
                      input logic ld, input logic o, input logic [3:0] bw,
                      input logic [7:0] a, input logic [35:0] d);
    cke_n = ck;
    {ce_a_n, ce_b_n, ce_c} = ce;
    wr_n = ~w;
    ld_n = ld;
    burst_ord = o;
    wr_lane_n = bw;
    addr = a;
    din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop(input logic [35:0] d);
    step(1'b0, DES, 1'b0, 1'b0, 1'b0, 4'hF, 8'h00, d);
  endtask

  task automatic check(input string req, input logic exp_en, input logic [35:0] exp_d);
    checks++;
    if (dq_en !== exp_en || (exp_en && dq_out !== exp_d)) begin
      errors++;
      $display("FAIL %s: actual en=%b data=%h expected en=%b data=%h",
               req, dq_en, dq_out, exp_en, exp_d);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
    cke_n = 1'b0; ce_a_n = 1'b1; ce_b_n = 1'b1; ce_c = 1'b0; wr_n = 1'b1;
    ld_n = 1'b0; burst_ord = 1'b0; wr_lane_n = 4'hF; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nop(ZW); nop(ZW); nop(ZW);
    check("R12 reset", 1'b0, ZW);

    // Table: mixed traffic, lanes, coherency (R1 R2 R4 R8 R11)
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].chk != 2'd0)
        check($sformatf("R1 R2 R4 R8 R11 row %0d", i), TBL[i].chk == 2'd1, TBL[i].exp);
      step(TBL[i].cke_n, TBL[i].sel ? SEL : DES, TBL[i].wr, TBL[i].ld_n,
           TBL[i].ilv, TBL[i].bw_n, TBL[i].a, TBL[i].d);
    end

    // R5 R6: prefill 0x20, then linear write burst from 0x21
    step(1'b0, SEL, 1'b1, 1'b0, 1'b0, 4'h0, 8'h20, ZW);
    nop(ZW);
    nop(P);
    step(1'b0, SEL, 1'b1, 1'b0, 1'b0, 4'h0, 8'h21, ZW);
    step(1'b0, DES, 1'b0, 1'b1, 1'b0, 4'h0, 8'h00, ZW);   // R6 ce/wr ignored
    step(1'b0, DES, 1'b0, 1'b1, 1'b0, 4'h0, 8'h00, B0);
    step(1'b0, DES, 1'b0, 1'b1, 1'b0, 4'hC, 8'h00, B1);   // R5 beat lanes 0,1
    nop(B2);
    nop(B3);

    // R7 interleaved read from 0x21: 21 20 23 22
    step(1'b0, SEL, 1'b0, 1'b0, 1'b1, 4'hF, 8'h21, ZW);
    step(1'b0, SEL, 1'b0, 1'b1, 1'b0, 4'hF, 8'h00, ZW);
    check("R7 xor beat0", 1'b1, B0);
    step(1'b0, SEL, 1'b0, 1'b1, 1'b0, 4'hF, 8'h00, ZW);
    check("R5 R7 xor beat1", 1'b1, W20);
    step(1'b0, SEL, 1'b0, 1'b1, 1'b0, 4'hF, 8'h00, ZW);
    check("R7 xor beat2", 1'b1, B2);
    nop(ZW);
    check("R7 xor beat3", 1'b1, B1);
    nop(ZW);
    check("R9 burst drained", 1'b0, ZW);

    // R6 R7 linear read from 0x23: 23 20 21 22
    step(1'b0, SEL, 1'b0, 1'b0, 1'b0, 4'hF, 8'h23, ZW);
    step(1'b0, SEL, 1'b0, 1'b1, 1'b1, 4'hF, 8'h00, ZW);
    check("R6 R7 lin beat0", 1'b1, B2);
    step(1'b0, SEL, 1'b0, 1'b1, 1'b1, 4'hF, 8'h00, ZW);
    check("R6 R7 lin beat1", 1'b1, W20);
    step(1'b0, SEL, 1'b0, 1'b1, 1'b1, 4'hF, 8'h00, ZW);
    check("R6 R7 lin beat2", 1'b1, B0);
    nop(ZW);
    check("R6 R7 lin beat3", 1'b1, B1);
    nop(ZW);

    // R3 clock-enable stall
    step(1'b0, SEL, 1'b0, 1'b0, 1'b0, 4'hF, 8'h21, ZW);
    step(1'b0, SEL, 1'b0, 1'b0, 1'b0, 4'hF, 8'h23, ZW);
    check("R3 before stall", 1'b1, B0);
    for (int s = 0; s < 3; s++) begin
      step(1'b1, SEL, 1'b1, 1'b0, 1'b0, 4'h0, 8'h22, D3);
      check("R3 stalled", 1'b1, B0);
    end
    nop(ZW);
    check("R3 after stall", 1'b1, B2);

    // R8 asynchronous output enable
    oe_n = 1'b1;
    #1;
    check("R8 oe_n high", 1'b0, ZW);
    oe_n = 1'b0;
    #1;
    check("R8 oe_n low", 1'b1, B2);
    nop(ZW);

    // R9 chip enables
    step(1'b0, 3'b011, 1'b0, 1'b0, 1'b0, 4'hF, 8'h21, ZW);
    nop(ZW);
    check("R9 ce_b_n high", 1'b0, ZW);
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 4'hF, 8'h21, ZW);
    nop(ZW);
    check("R9 ce_c low", 1'b0, ZW);
    step(1'b0, SEL, 1'b0, 1'b0, 1'b0, 4'hF, 8'h21, ZW);
    nop(ZW);
    check("R9 selected", 1'b1, B0);
    nop(ZW);

    // R10 sleep
    sleep = 1'b1;
    nop(ZW); nop(ZW); nop(ZW);
    step(1'b0, SEL, 1'b0, 1'b0, 1'b0, 4'hF, 8'h21, ZW);
    nop(ZW);
    check("R10 asleep read", 1'b0, ZW);
    step(1'b0, SEL, 1'b1, 1'b0, 1'b0, 4'h0, 8'h21, ZW);
    nop(ZW);
    nop(D3);
    sleep = 1'b0;
    nop(ZW);
    check("R10 exit high-Z", 1'b0, ZW);
    nop(ZW); nop(ZW);
    step(1'b0, SEL, 1'b0, 1'b0, 1'b0, 4'hF, 8'h21, ZW);
    nop(ZW);
    check("R10 awake retained", 1'b1, B0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule